// File: doc/BRIEF.md
# Motor Speed Discriminator with Lock Detect

This block measures the period of a motor tachometer signal by counting cycles of a reference clock, and compares that count with a target count. The reference clock is an external clock multiplied by a divisor, so the target count is what the counter reads when the motor runs at the commanded speed. Two select pins choose the target count and the divisor together. The divisor goes out to the VCO divider. Some settings halve the commanded speed at the same external clock frequency.

The tachometer arrives as a synchronized single-cycle edge strobe. The block measures one tachometer period and then skips the next one, so it delivers one result for every two periods. Each result updates a direction flag (speed up or slow down) and an active-low lock flag. It also fires an error pulse on the accelerate or the decelerate line. The pulse width tracks the size of the error and feeds a downstream integrator.

Top module: `speed_discrim`

## Requirements
- R1: The select pins choose (target count, divisor) as follows, with the pins written {sel_a_i, sel_b_i}: 11 gives (1024, 1024), 10 gives (1024, 512), 01 gives (256, 256) and 00 gives (512, 512). `vco_div_o` shows the divisor of the setting sampled on the previous clock, and reset loads setting 11.
- R2: The measured count is the number of reference cycles between two successive `fg_edge_i` strobes. The first strobe after reset or after a restart only opens a measurement. The strobe that closes a measurement produces a result. The period that follows is skipped: the strobe that ends it starts a new measurement and produces no result.
- R3: At each result, `err_dir_o` becomes 1 if the measured count exceeds the target and 0 otherwise. Outside of results it holds its value.
- R4: At each result, `lock_no` becomes 0 when |measured − target| ≤ target/16 (integer, bounds included), and 1 otherwise.
- R5: A result starts a pulse in the cycle after the closing strobe. The pulse runs on `accel_o` when measured > target and on `decel_o` when measured < target. Its width in cycles is min(|measured − target|, 255). An exact match gives no pulse. A new result replaces a pulse in progress, and the two lines are never high together.
- R6: The period count saturates at twice the target. A saturated measurement reports accelerate, not locked, and a pulse clamped at 255.
- R7: A change of either select pin restarts the measurement. `lock_no` goes to 1 and any pulse stops in the next cycle, and the block then waits for a fresh measurement.
- R8: During and after reset, `lock_no` is 1, `accel_o`, `decel_o` and `err_dir_o` are 0, and `vco_div_o` is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (external clock times divisor) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fg_edge_i | input | 1 | Synchronized tachometer edge strobe, one cycle wide |
| sel_a_i | input | 1 | Speed setting select, upper bit |
| sel_b_i | input | 1 | Speed setting select, lower bit |
| accel_o | output | 1 | Accelerate error pulse |
| decel_o | output | 1 | Decelerate error pulse |
| err_dir_o | output | 1 | Direction of the last result, 1 = accelerate |
| lock_no | output | 1 | Speed lock, active low |
| vco_div_o | output | 11 | Divisor for the VCO divider |

## Verification
The bench sends periods exactly on both edges of the lock window (target ± target/16) and one cycle past each edge. A design with an exclusive bound or an off-by-one count would flip the lock flag there and change the pulse width by one. Long periods check that the counter saturates at twice the target and that the pulse is clamped. A wrapping counter would report a short period and the wrong direction. A strobe that ends a skipped period must leave every output untouched, because a design that measured every period would produce an extra result. Select changes in the middle of a pulse and while locked check that the pulse stops at once and that the lock flag is dropped. They also check that the first strobe after the change produces no result.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_MEAS, PH_SKIP} sd_phase_e;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sd_cfg_decode.sv
module sd_cfg_decode #(
  parameter int CW     = 12,
  parameter int DW     = 11,
  parameter int CNT_HH = 1024, parameter int DIV_HH = 1024,
  parameter int CNT_HL = 1024, parameter int DIV_HL = 512,
  parameter int CNT_LH = 256,  parameter int DIV_LH = 256,
  parameter int CNT_LL = 512,  parameter int DIV_LL = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_a_i,
  input  logic          sel_b_i,
  output logic [CW-1:0] tgt_o,
  output logic [DW-1:0] div_o,
  output logic          restart_o
);
  logic [1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 2'b11;
    else         sel_q <= {sel_a_i, sel_b_i};
  end

  assign restart_o = (sel_q != {sel_a_i, sel_b_i});

  always_comb begin
    unique case (sel_q)
      2'b11:   begin tgt_o = CW'(CNT_HH); div_o = DW'(DIV_HH); end
      2'b10:   begin tgt_o = CW'(CNT_HL); div_o = DW'(DIV_HL); end
      2'b01:   begin tgt_o = CW'(CNT_LH); div_o = DW'(DIV_LH); end
      default: begin tgt_o = CW'(CNT_LL); div_o = DW'(DIV_LL); end
    endcase
  end
endmodule

// File: rtl/sd_period_meter.sv
module sd_period_meter #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          fg_edge_i,
  input  logic [CW-1:0] tgt_i,
  output logic          done_o,
  output logic [CW-1:0] meas_o
);
  import sd_pkg::*;

  sd_phase_e     ph_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] sat;

  assign sat = tgt_i << 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (restart_i) begin
      ph_q  <= PH_IDLE;
    end else if (fg_edge_i) begin
      unique case (ph_q)
        PH_IDLE: begin ph_q <= PH_MEAS; cnt_q <= CW'(1); end
        PH_MEAS: ph_q <= PH_SKIP;
        PH_SKIP: begin ph_q <= PH_MEAS; cnt_q <= CW'(1); end
        default: ph_q <= PH_IDLE;
      endcase
    end else if (ph_q == PH_MEAS && cnt_q < sat) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // closing strobe of a measured period
  assign done_o = fg_edge_i && !restart_i && (ph_q == PH_MEAS);
  assign meas_o = cnt_q;
endmodule

// File: rtl/sd_judge.sv
module sd_judge #(
  parameter int CW        = 12,
  parameter int PULSE_MAX = 255,
  localparam int PWW      = $clog2(PULSE_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          done_i,
  input  logic [CW-1:0] meas_i,
  input  logic [CW-1:0] tgt_i,
  output logic          dir_o,
  output logic          lock_no,
  output logic          accel_o,
  output logic          decel_o
);
  logic [CW-1:0]  diff;
  logic           slow;
  logic           in_win;
  logic [PWW-1:0] width;
  logic [PWW-1:0] pcnt_q;

  assign slow   = meas_i > tgt_i;
  assign diff   = slow ? (meas_i - tgt_i) : (tgt_i - meas_i);
  assign in_win = diff <= (tgt_i >> 4);
  assign width  = (diff > CW'(PULSE_MAX)) ? PWW'(PULSE_MAX) : diff[PWW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= 1'b0;
      lock_no <= 1'b1;
      pcnt_q  <= '0;
    end else if (restart_i) begin
      lock_no <= 1'b1;
      pcnt_q  <= '0;
    end else if (done_i) begin
      dir_o   <= slow;
      lock_no <= !in_win;
      pcnt_q  <= width;
    end else if (pcnt_q != '0) begin
      pcnt_q  <= pcnt_q - PWW'(1);
    end
  end

  assign accel_o = (pcnt_q != '0) &&  dir_o;
  assign decel_o = (pcnt_q != '0) && !dir_o;
endmodule

// File: rtl/speed_discrim.sv
module speed_discrim #(
  parameter int CNT_HH    = 1024, parameter int DIV_HH = 1024,
  parameter int CNT_HL    = 1024, parameter int DIV_HL = 512,
  parameter int CNT_LH    = 256,  parameter int DIV_LH = 256,
  parameter int CNT_LL    = 512,  parameter int DIV_LL = 512,
  parameter int PULSE_MAX = 255,
  localparam int CNT_MAX  = sd_pkg::max4(CNT_HH, CNT_HL, CNT_LH, CNT_LL),
  localparam int DIV_MAX  = sd_pkg::max4(DIV_HH, DIV_HL, DIV_LH, DIV_LL),
  localparam int CW       = $clog2(2 * CNT_MAX + 1),
  localparam int DW       = $clog2(DIV_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fg_edge_i,
  input  logic          sel_a_i,
  input  logic          sel_b_i,
  output logic          accel_o,
  output logic          decel_o,
  output logic          err_dir_o,
  output logic          lock_no,
  output logic [DW-1:0] vco_div_o
);
  logic [CW-1:0] tgt;
  logic [CW-1:0] meas;
  logic          restart;
  logic          done;

  sd_cfg_decode #(
    .CW(CW), .DW(DW),
    .CNT_HH(CNT_HH), .DIV_HH(DIV_HH), .CNT_HL(CNT_HL), .DIV_HL(DIV_HL),
    .CNT_LH(CNT_LH), .DIV_LH(DIV_LH), .CNT_LL(CNT_LL), .DIV_LL(DIV_LL)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .tgt_o(tgt), .div_o(vco_div_o), .restart_o(restart)
  );

  sd_period_meter #(.CW(CW)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .fg_edge_i(fg_edge_i),
    .tgt_i(tgt), .done_o(done), .meas_o(meas)
  );

  sd_judge #(.CW(CW), .PULSE_MAX(PULSE_MAX)) u_judge (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .done_i(done),
    .meas_i(meas), .tgt_i(tgt), .dir_o(err_dir_o), .lock_no(lock_no),
    .accel_o(accel_o), .decel_o(decel_o)
  );
endmodule

// File: rtl/sd_discrim_chk.sv
module sd_discrim_chk #(
  parameter int DW     = 11,
  parameter int DIV_HH = 1024,
  parameter int DIV_HL = 512,
  parameter int DIV_LH = 256,
  parameter int DIV_LL = 512
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fg_edge_i,
  input logic          sel_a_i,
  input logic          sel_b_i,
  input logic          accel_o,
  input logic          decel_o,
  input logic          err_dir_o,
  input logic          lock_no,
  input logic [DW-1:0] vco_div_o
);
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accel_o && decel_o));

  a_r5_pulse_matches_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accel_o |-> err_dir_o) and (decel_o |-> !err_dir_o));

  a_r5_pulse_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(accel_o) || $rose(decel_o)) |-> $past(fg_edge_i));

  a_r4_lock_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_no) |-> $past(fg_edge_i));

  a_r3_dir_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fg_edge_i) |-> $stable(err_dir_o));

  a_r7_sel_change_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_i != $past(sel_a_i) || sel_b_i != $past(sel_b_i)) |=> (lock_no && !accel_o && !decel_o));

  a_r1_div_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_div_o == DW'(DIV_HH) || vco_div_o == DW'(DIV_HL) ||
    vco_div_o == DW'(DIV_LH) || vco_div_o == DW'(DIV_LL));
endmodule

bind speed_discrim sd_discrim_chk #(
  .DW(DW), .DIV_HH(DIV_HH), .DIV_HL(DIV_HL), .DIV_LH(DIV_LH), .DIV_LL(DIV_LL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fg_edge_i(fg_edge_i),
  .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .accel_o(accel_o), .decel_o(decel_o),
  .err_dir_o(err_dir_o), .lock_no(lock_no), .vco_div_o(vco_div_o)
);

// File: tb/speed_discrim_tb.sv
module speed_discrim_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fg = 1'b0;
  logic        sa = 1'b1;
  logic        sb = 1'b1;
  logic        accel, decel, dir, lock_n;
  logic [10:0] div;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  speed_discrim u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fg_edge_i(fg), .sel_a_i(sa), .sel_b_i(sb),
    .accel_o(accel), .decel_o(decel), .err_dir_o(dir), .lock_no(lock_n),
    .vco_div_o(div)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tgt_of(input int s);
    case (s)
      3: return 1024;
      2: return 1024;
      1: return 256;
      default: return 512;
    endcase
  endfunction

  function automatic int div_of(input int s);
    case (s)
      3: return 1024;
      2: return 512;
      1: return 256;
      default: return 512;
    endcase
  endfunction

  // behavioural reference: phase 0 wait, 1 measuring, 2 skipping
  int m_ph, m_cnt, m_prev, m_dir, m_lockn, m_pw;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_prev = 3; m_dir = 0; m_lockn = 1; m_pw = 0;
    end else begin
      int s, t, d;
      bit loaded;
      s = {sa, sb};
      t = tgt_of(m_prev);
      loaded = 1'b0;
      if (s != m_prev) begin
        m_ph = 0; m_lockn = 1; m_pw = 0;
      end else begin
        if (fg) begin
          if (m_ph == 1) begin
            d = (m_cnt > t) ? m_cnt - t : t - m_cnt;
            m_dir = (m_cnt > t);
            m_lockn = (d <= t / 16) ? 0 : 1;
            m_pw = (d > 255) ? 255 : d;
            loaded = 1'b1;
            m_ph = 2;
          end else begin
            m_ph = 1; m_cnt = 1;
          end
        end else if (m_ph == 1 && m_cnt < 2 * t) begin
          m_cnt = m_cnt + 1;
        end
        if (!loaded && m_pw > 0) m_pw = m_pw - 1;
      end
      m_prev = s;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 accel_o vs model", int'(accel), (m_pw > 0 && m_dir == 1) ? 1 : 0);
      chk("R5 decel_o vs model", int'(decel), (m_pw > 0 && m_dir == 0) ? 1 : 0);
      chk("R3 err_dir_o vs model", int'(dir), m_dir);
      chk("R4 lock_no vs model", int'(lock_n), m_lockn);
      chk("R1 vco_div_o vs model", int'(div), div_of(m_prev));
    end
  end

  task automatic edge1();
    fg = 1'b1;
    @(negedge clk);
    fg = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // open and close one measured period of n cycles
  task automatic result(input int n);
    edge1();
    idle(n - 1);
    edge1();
  endtask

  task automatic pulse_len(output int na, output int nd);
    na = 0; nd = 0;
    for (int i = 0; i < 400 && (accel || decel); i++) begin
      if (accel) na++;
      if (decel) nd++;
      @(negedge clk);
    end
  endtask

  initial begin
    int na, nd;
    @(negedge clk);
    chk("R8 lock_no in reset", int'(lock_n), 1);
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 lock_no after reset", int'(lock_n), 1);
    chk("R8 pulses after reset", int'(accel) + int'(decel), 0);
    chk("R8 dir after reset", int'(dir), 0);
    chk("R8 div after reset", int'(div), 1024);
    idle(20);

    result(1024);
    chk("R4 exact period locks", int'(lock_n), 0);
    pulse_len(na, nd);
    chk("R5 exact period no pulse", na + nd, 0);

    idle(50); result(1088);
    chk("R4 upper bound inclusive", int'(lock_n), 0);
    chk("R3 slow means accelerate", int'(dir), 1);
    pulse_len(na, nd);
    chk("R5 accel width 64", na, 64);
    chk("R5 no decel", nd, 0);

    idle(50); result(1089);
    chk("R4 past upper bound", int'(lock_n), 1);
    pulse_len(na, nd);
    chk("R5 accel width 65", na, 65);

    idle(50); result(960);
    chk("R4 lower bound inclusive", int'(lock_n), 0);
    chk("R3 fast means decelerate", int'(dir), 0);
    pulse_len(na, nd);
    chk("R5 decel width 64", nd, 64);

    idle(50); result(959);
    chk("R4 past lower bound", int'(lock_n), 1);
    pulse_len(na, nd);
    chk("R5 decel width 65", nd, 65);

    idle(50); result(3000);
    chk("R6 saturated unlocked", int'(lock_n), 1);
    chk("R6 saturated accelerate", int'(dir), 1);
    pulse_len(na, nd);
    chk("R6 clamped width", na, 255);

    idle(50); result(1024);
    chk("R2 relock", int'(lock_n), 0);
    idle(2000);
    edge1(); // ends the skipped period
    chk("R2 skip strobe keeps lock", int'(lock_n), 0);
    chk("R2 skip strobe no pulse", int'(accel) + int'(decel), 0);
    idle(1499);
    edge1();
    chk("R2 measured after skip", int'(lock_n), 1);
    chk("R2 measured after skip dir", int'(dir), 1);
    pulse_len(na, nd);
    chk("R2 clamp after skip", na, 255);

    idle(50); result(1024);
    chk("R7 locked before change", int'(lock_n), 0);
    sa = 1'b0;
    @(negedge clk);
    chk("R7 change unlocks", int'(lock_n), 1);
    chk("R1 divisor 256", int'(div), 256);
    edge1();
    chk("R7 first strobe no result", int'(lock_n), 1);
    idle(255);
    edge1();
    chk("R1 target 256 locks", int'(lock_n), 0);

    idle(50); result(1300);
    chk("R6 saturation at 512", int'(dir), 1);
    idle(10);
    chk("R7 pulse active", int'(accel), 1);
    sb = 1'b0;
    @(negedge clk);
    chk("R7 pulse stopped", int'(accel) + int'(decel), 0);
    chk("R1 divisor 512 mode 00", int'(div), 512);

    idle(20); result(544);
    chk("R1 target 512 locked", int'(lock_n), 0);
    pulse_len(na, nd);
    chk("R5 accel width 32", na, 32);
    idle(50); result(545);
    chk("R4 target 512 unlocked", int'(lock_n), 1);

    sa = 1'b1;
    idle(20);
    chk("R1 divisor 512 mode 10", int'(div), 512);
    result(1024);
    chk("R1 target 1024 mode 10", int'(lock_n), 0);
    idle(20);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule